// File: doc/BRIEF.md
# Multi-Channel Up-Counting Event Timer

This block is a bus-attached bank of independent up-counting timer channels, six by default, numbered from 1. Each channel advances on a tick drawn from one of two clock-enable inputs (a fast system tick and a slow real-time tick), optionally halved by a per-channel divide-by-two stage. A channel runs in one of three modes: it counts freely and wraps, it raises an event and restarts from zero each time it reaches its compare value, or it raises a single event and then switches itself off.

Events land in a shared set of pending flags, one per channel. A shared mask register decides which flags drive the single level interrupt output, and software clears flags by writing ones to an acknowledge register. All registers are reached through a plain single-cycle 32-bit write port and a combinational read port.

Top module: `gp_timer_bank`

## Requirements
- R1: After a synchronous active-low reset every register reads 0 (mask, pending flags, and each channel's control, clock, count and compare words) and `irq` is low.
- R2: The control word of channel n is at byte offset 0x10*n: bit 0 enables counting, bit 1 clears the count, bits 5:4 pick the mode. In mode 3 (free-run) the count rises by one on each selected tick, wraps from all-ones to 0 and never sets a pending flag.
- R3: In mode 1 (repeat), the tick that would bring the count to the compare value (offset 0x0C+0x10*n) instead sets the channel's pending flag and loads 0; counting then continues.
- R4: In mode 0 (one-shot; mode 2 behaves the same), the tick that brings the count to the compare value sets the pending flag, leaves the count at that value and clears the enable bit, so counting stops.
- R5: Writing a control word with bit 1 set zeroes the count (offset 0x08+0x10*n) at that write; bit 1 always reads back 0. Enable and clear in one write restart counting from 0.
- R6: While the enable bit is 0 the count holds its value whatever ticks arrive.
- R7: The clock word at offset 0x04+0x10*n takes bit 4 as the source (0 = system tick, 1 = real-time tick) and bit 0 as the divider (0 = every tick, 1 = every second tick of the chosen source, counted from the last clear).
- R8: Writing the acknowledge register (offset 0x08) clears the pending flag of channel n for each 1 in bit n-1; zero bits leave flags alone, and 0x3F clears all six. Reading it returns the pending flags.
- R9: `irq` is high exactly when some channel has both its pending flag and its bit n-1 in the mask register (offset 0x00) set.
- R10: A new compare value applies to the next tick without any restart of the channel.
- R11: If a channel event and an acknowledge of the same flag fall in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_sys_en | input | 1 | Fast tick enable, one cycle per tick |
| tick_rtc_en | input | 1 | Slow tick enable, one cycle per tick |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
Every register write and every tick takes effect at the clock edge where it is sampled, so counts, flags, enable bits and `irq` all move on that one edge and read data follows the address within the same cycle. The bench drives strobes and ticks on the falling edge, holds them for exactly one rising edge per tick, and reads back one falling edge later, so each check sees the state one edge after its stimulus. Tick counts are chosen so that the expected count, flag and enable values follow by arithmetic from the compare value and mode; the bench instantiates an 8-bit counter so that free-run wrap is reached in a few hundred cycles.

// File: rtl/gpt_pkg.sv
// Shared constants and types for the timer bank.
// Assumes a byte-addressed register space with a 16-byte window per channel.
package gpt_pkg;

    // Shared register offsets
    localparam int OFS_MASK   = 'h00;
    localparam int OFS_ACK    = 'h08;
    // Per-channel window: base = CH_STRIDE * channel number (1-based)
    localparam int CH_STRIDE  = 'h10;
    localparam int SUB_CTRL   = 'h0;
    localparam int SUB_CLK    = 'h4;
    localparam int SUB_CNT    = 'h8;
    localparam int SUB_CMP    = 'hC;

    // Control word fields
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_CLR_BIT  = 1;
    localparam int CTRL_MODE_LSB = 4;

    // Clock word fields
    localparam int CLK_DIV_BIT = 0;
    localparam int CLK_SRC_BIT = 4;

    typedef enum logic [1:0] {
        MODE_ONESHOT = 2'd0,
        MODE_REPEAT  = 2'd1,
        MODE_SPARE   = 2'd2,
        MODE_FREERUN = 2'd3
    } gpt_mode_e;

endpackage

// File: rtl/gpt_tick_sel.sv
// Tick selection and divide-by-two stage for one channel.
// Assumes the tick inputs are single-cycle clock enables in the clk domain.
// The divider phase restarts whenever the channel count is cleared.
module gpt_tick_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_tick,
    input  logic rtc_tick,
    input  logic use_rtc,
    input  logic halve,
    input  logic restart,
    output logic tick
);

    logic src_tick;
    logic phase_q;

    // Pick the tick source named by the clock word
    assign src_tick = use_rtc ? rtc_tick : sys_tick;

    // Track odd/even source ticks for the divide-by-two setting
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= 1'b0;
        else if (restart)
            phase_q <= 1'b0;
        else if (src_tick && halve)
            phase_q <= ~phase_q;
    end

    // Pass every tick, or every second tick when halving
    assign tick = src_tick && (!halve || phase_q);

endmodule

// File: rtl/gpt_channel.sv
// One timer channel: control, clock, compare and count registers.
// Assumes at most one register write per cycle; a control write in a cycle
// takes precedence over a tick arriving in that same cycle.
module gpt_channel
    import gpt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctrl_we,
    input  logic             wr_en,
    input  logic             wr_clr,
    input  logic [1:0]       wr_mode,
    input  logic             clk_we,
    input  logic             wr_src,
    input  logic             wr_div,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] wr_cmp,
    output logic             en,
    output logic [1:0]       mode,
    output logic             src_rtc,
    output logic             div2,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cmp,
    output logic             hit
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             en_q;
    gpt_mode_e        mode_q;
    logic             src_q;
    logic             div_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             advance;
    logic             is_free;
    logic             is_rep;

    assign cnt_inc = cnt_q + ONE;
    assign is_free = (mode_q == MODE_FREERUN);
    assign is_rep  = (mode_q == MODE_REPEAT);
    assign advance = tick && en_q && !ctrl_we;
    assign hit     = advance && !is_free && (cnt_inc == cmp_q);

    // Control word: enable and mode, with one-shot self-disable on event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= MODE_ONESHOT;
        end else if (ctrl_we) begin
            en_q   <= wr_en;
            mode_q <= gpt_mode_e'(wr_mode);
        end else if (hit && !is_rep) begin
            en_q   <= 1'b0;
        end
    end

    // Clock word: source select and divider
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= 1'b0;
            div_q <= 1'b0;
        end else if (clk_we) begin
            src_q <= wr_src;
            div_q <= wr_div;
        end
    end

    // Compare value, used from the next tick onward
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_q <= '0;
        else if (cmp_we)
            cmp_q <= wr_cmp;
    end

    // Counter: clear pulse, reload on repeat event, otherwise increment
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (ctrl_we) begin
            if (wr_clr)
                cnt_q <= '0;
        end else if (advance) begin
            if (hit && is_rep)
                cnt_q <= '0;
            else
                cnt_q <= cnt_inc;
        end
    end

    assign en      = en_q;
    assign mode    = mode_q;
    assign src_rtc = src_q;
    assign div2    = div_q;
    assign count   = cnt_q;
    assign cmp     = cmp_q;

endmodule

// File: rtl/gpt_irq_ctrl.sv
// Shared pending flags, interrupt mask and the level interrupt output.
// Assumes channel events are single-cycle pulses; an event beats an
// acknowledge of the same flag in the same cycle.
module gpt_irq_ctrl #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic              ack_we,
    input  logic [NUM_CH-1:0] wr_bits,
    input  logic [NUM_CH-1:0] hit,
    output logic [NUM_CH-1:0] mask,
    output logic [NUM_CH-1:0] pend,
    output logic              irq
);

    logic [NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0] pend_q;
    logic [NUM_CH-1:0] ack_bits;

    assign ack_bits = ack_we ? wr_bits : '0;

    // Interrupt mask register
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_we)
            mask_q <= wr_bits;
    end

    // Pending flags: acknowledged bits drop, new events set
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~ack_bits) | hit;
    end

    assign mask = mask_q;
    assign pend = pend_q;
    assign irq  = |(pend_q & mask_q);

endmodule

// File: rtl/gpt_reg_read.sv
// Combinational read multiplexer over the shared and per-channel registers.
// Assumes unmapped addresses read as zero and CNT_W <= DATA_W.
module gpt_reg_read
    import gpt_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [NUM_CH-1:0]       mask,
    input  logic [NUM_CH-1:0]       pend,
    input  logic [NUM_CH-1:0]       en,
    input  logic [2*NUM_CH-1:0]     mode_flat,
    input  logic [NUM_CH-1:0]       src_rtc,
    input  logic [NUM_CH-1:0]       div2,
    input  logic [NUM_CH*CNT_W-1:0] cnt_flat,
    input  logic [NUM_CH*CNT_W-1:0] cmp_flat,
    output logic [DATA_W-1:0]       rdata
);

    localparam int IDX_W = ADDR_W - 4;

    logic [IDX_W-1:0] win_idx;
    logic [3:0]       win_ofs;

    assign win_idx = addr[ADDR_W-1:4];
    assign win_ofs = addr[3:0];

    // Select the word addressed on the bus
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_MASK))
            rdata[NUM_CH-1:0] = mask;
        else if (addr == ADDR_W'(OFS_ACK))
            rdata[NUM_CH-1:0] = pend;
        for (int i = 0; i < NUM_CH; i++) begin
            if (win_idx == IDX_W'(i + 1)) begin
                case (win_ofs)
                    4'(SUB_CTRL): begin
                        rdata[CTRL_EN_BIT] = en[i];
                        rdata[CTRL_MODE_LSB +: 2] = mode_flat[2*i +: 2];
                    end
                    4'(SUB_CLK): begin
                        rdata[CLK_DIV_BIT] = div2[i];
                        rdata[CLK_SRC_BIT] = src_rtc[i];
                    end
                    4'(SUB_CNT): rdata[CNT_W-1:0] = cnt_flat[CNT_W*i +: CNT_W];
                    4'(SUB_CMP): rdata[CNT_W-1:0] = cmp_flat[CNT_W*i +: CNT_W];
                    default:     rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/gp_timer_bank.sv
// Top of the timer bank: write decode, one channel and tick stage per
// channel, shared interrupt control and read multiplexer.
// Assumes NUM_CH fits in the address window (NUM_CH < 2**(ADDR_W-4)) and
// NUM_CH <= DATA_W, CNT_W <= DATA_W.
module gp_timer_bank
    import gpt_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_sys_en,
    input  logic              tick_rtc_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic [NUM_CH-1:0]       mask_q;
    logic [NUM_CH-1:0]       pend_q;
    logic [NUM_CH-1:0]       ch_en;
    logic [NUM_CH-1:0]       ch_hit;
    logic [NUM_CH-1:0]       ch_tick;
    logic [NUM_CH-1:0]       ch_ctrl_we;
    logic [NUM_CH-1:0]       ch_src;
    logic [NUM_CH-1:0]       ch_div;
    logic [2*NUM_CH-1:0]     mode_flat;
    logic [NUM_CH*CNT_W-1:0] cnt_flat;
    logic [NUM_CH*CNT_W-1:0] cmp_flat;
    logic                    mask_we;
    logic                    ack_we;

    // Shared register write strobes
    assign mask_we = bus_wr && (bus_addr == ADDR_W'(OFS_MASK));
    assign ack_we  = bus_wr && (bus_addr == ADDR_W'(OFS_ACK));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CH_STRIDE*(g+1) + SUB_CTRL);
        localparam logic [ADDR_W-1:0] A_CLK  = ADDR_W'(CH_STRIDE*(g+1) + SUB_CLK);
        localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(CH_STRIDE*(g+1) + SUB_CMP);

        logic clk_we;
        logic cmp_we;
        logic clr_pulse;

        assign ch_ctrl_we[g] = bus_wr && (bus_addr == A_CTRL);
        assign clk_we        = bus_wr && (bus_addr == A_CLK);
        assign cmp_we        = bus_wr && (bus_addr == A_CMP);
        assign clr_pulse     = ch_ctrl_we[g] && bus_wdata[CTRL_CLR_BIT];

        gpt_tick_sel u_tick (
            .clk      (clk),
            .rst_n    (rst_n),
            .sys_tick (tick_sys_en),
            .rtc_tick (tick_rtc_en),
            .use_rtc  (ch_src[g]),
            .halve    (ch_div[g]),
            .restart  (clr_pulse),
            .tick     (ch_tick[g])
        );

        gpt_channel #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (ch_tick[g]),
            .ctrl_we (ch_ctrl_we[g]),
            .wr_en   (bus_wdata[CTRL_EN_BIT]),
            .wr_clr  (bus_wdata[CTRL_CLR_BIT]),
            .wr_mode (bus_wdata[CTRL_MODE_LSB +: 2]),
            .clk_we  (clk_we),
            .wr_src  (bus_wdata[CLK_SRC_BIT]),
            .wr_div  (bus_wdata[CLK_DIV_BIT]),
            .cmp_we  (cmp_we),
            .wr_cmp  (bus_wdata[CNT_W-1:0]),
            .en      (ch_en[g]),
            .mode    (mode_flat[2*g +: 2]),
            .src_rtc (ch_src[g]),
            .div2    (ch_div[g]),
            .count   (cnt_flat[CNT_W*g +: CNT_W]),
            .cmp     (cmp_flat[CNT_W*g +: CNT_W]),
            .hit     (ch_hit[g])
        );
    end

    gpt_irq_ctrl #(
        .NUM_CH (NUM_CH)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (mask_we),
        .ack_we  (ack_we),
        .wr_bits (bus_wdata[NUM_CH-1:0]),
        .hit     (ch_hit),
        .mask    (mask_q),
        .pend    (pend_q),
        .irq     (irq)
    );

    gpt_reg_read #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_rd (
        .addr      (bus_addr),
        .mask      (mask_q),
        .pend      (pend_q),
        .en        (ch_en),
        .mode_flat (mode_flat),
        .src_rtc   (ch_src),
        .div2      (ch_div),
        .cnt_flat  (cnt_flat),
        .cmp_flat  (cmp_flat),
        .rdata     (bus_rdata)
    );

endmodule

// File: rtl/gpt_timer_checker.sv
// Protocol checks for the timer bank, bound to the top module.
// Assumes the bound signals keep the names used in gp_timer_bank.
module gpt_timer_checker
    import gpt_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wr,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [DATA_W-1:0]       bus_wdata,
    input logic                    irq,
    input logic [NUM_CH-1:0]       pend,
    input logic [NUM_CH-1:0]       ch_en,
    input logic [NUM_CH-1:0]       ch_hit,
    input logic [NUM_CH-1:0]       ch_ctrl_we,
    input logic [2*NUM_CH-1:0]     mode_flat,
    input logic [NUM_CH*CNT_W-1:0] cnt_flat
);

    // Without any pending flag the interrupt stays low
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> !irq); // R9

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            ch_hit[i] |=> pend[i]); // R3

        AST_FREERUN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_flat[2*i +: 2] == 2'd3) |-> !ch_hit[i]); // R2

        AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_hit[i] && !mode_flat[2*i]) |=> !ch_en[i]); // R4

        AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_en[i] && !ch_ctrl_we[i]) |=> $stable(cnt_flat[CNT_W*i +: CNT_W])); // R6

        AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(OFS_ACK) && bus_wdata[i] && !ch_hit[i])
            |=> !pend[i]); // R8
    end

endmodule

bind gp_timer_bank gpt_timer_checker #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .irq        (irq),
    .pend       (pend_q),
    .ch_en      (ch_en),
    .ch_hit     (ch_hit),
    .ch_ctrl_we (ch_ctrl_we),
    .mode_flat  (mode_flat),
    .cnt_flat   (cnt_flat)
);

// File: tb/tb_gp_timer_bank.sv
// Directed bench for gp_timer_bank, one task per scenario.
module tb_gp_timer_bank;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_sys_en = 1'b0;
    logic        tick_rtc_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;

    gp_timer_bank #(.NUM_CH(6), .CNT_W(CW), .ADDR_W(8), .DATA_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .tick_sys_en(tick_sys_en), .tick_rtc_en(tick_rtc_en),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic sys_ticks(input int n);
        @(negedge clk);
        tick_sys_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_sys_en = 1'b0;
    endtask

    task automatic rtc_ticks(input int n);
        @(negedge clk);
        tick_rtc_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_rtc_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(8'h00, d); check(d, 0, "R1 mask");
        rd(8'h08, d); check(d, 0, "R1 pending");
        for (int a = 16; a < 112; a += 4) begin
            rd(8'(a), d); check(d, 0, "R1 channel word");
        end
        check({31'd0, irq}, 0, "R1 irq");
    endtask

    task automatic t_freerun;
        logic [31:0] d;
        wr(8'h14, 32'h0);
        wr(8'h10, 32'h33);
        sys_ticks(10);
        rd(8'h18, d); check(d, 10, "R2 count after 10 ticks");
        sys_ticks(246);
        rd(8'h18, d); check(d, 0, "R2 wrap to zero");
        rd(8'h08, d); check(d & 32'h1, 0, "R2 no flag in free-run");
        rd(8'h10, d); check(d, 32'h31, "R5 clear bit reads 0");
    endtask

    task automatic t_repeat_irq;
        logic [31:0] d;
        wr(8'h00, 32'h02);
        wr(8'h2C, 32'd5);
        wr(8'h20, 32'h13);
        sys_ticks(4);
        rd(8'h28, d); check(d, 4, "R3 count before compare");
        check({31'd0, irq}, 0, "R9 irq low before event");
        sys_ticks(1);
        rd(8'h28, d); check(d, 0, "R3 reload to zero");
        rd(8'h08, d); check(d & 32'h2, 32'h2, "R3 flag set");
        check({31'd0, irq}, 1, "R9 irq high");
        sys_ticks(3);
        rd(8'h28, d); check(d, 3, "R3 keeps running");
        wr(8'h08, 32'h01);
        rd(8'h08, d); check(d & 32'h2, 32'h2, "R8 zero bit leaves flag");
        wr(8'h08, 32'h02);
        rd(8'h08, d); check(d & 32'h2, 0, "R8 ack clears flag");
        check({31'd0, irq}, 0, "R9 irq low after ack");
        wr(8'h00, 32'h00);
        sys_ticks(2);
        rd(8'h08, d); check(d & 32'h2, 32'h2, "R3 second event");
        check({31'd0, irq}, 0, "R9 masked flag keeps irq low");
        wr(8'h00, 32'h02);
        check({31'd0, irq}, 1, "R9 unmask raises irq");
        wr(8'h08, 32'h3F);
        rd(8'h08, d); check(d, 0, "R8 clear all");
    endtask

    task automatic t_oneshot;
        logic [31:0] d;
        wr(8'h3C, 32'd3);
        wr(8'h30, 32'h03);
        sys_ticks(5);
        rd(8'h38, d); check(d, 3, "R4 count holds compare");
        rd(8'h30, d); check(d, 0, "R4 enable cleared");
        rd(8'h08, d); check(d & 32'h4, 32'h4, "R4 flag set");
        wr(8'h08, 32'h3F);
    endtask

    task automatic t_freeze_clear;
        logic [31:0] d;
        logic [31:0] held;
        sys_ticks(2);
        wr(8'h20, 32'h10);
        rd(8'h28, held);
        sys_ticks(4);
        rd(8'h28, d); check(d, held, "R6 count frozen");
        rd(8'h20, d); check(d, 32'h10, "R5 control readback");
        wr(8'h20, 32'h12);
        rd(8'h28, d); check(d, 0, "R5 clear zeroes count");
    endtask

    task automatic t_cmp_update;
        logic [31:0] d;
        wr(8'h2C, 32'd5);
        wr(8'h20, 32'h13);
        sys_ticks(2);
        rd(8'h28, d); check(d, 2, "R10 count before update");
        wr(8'h2C, 32'd3);
        sys_ticks(1);
        rd(8'h28, d); check(d, 0, "R10 new compare used");
        rd(8'h08, d); check(d & 32'h2, 32'h2, "R10 flag from new compare");
        wr(8'h20, 32'h10);
        wr(8'h08, 32'h3F);
    endtask

    task automatic t_clock_sel;
        logic [31:0] d;
        wr(8'h44, 32'h10);
        wr(8'h40, 32'h33);
        sys_ticks(3);
        rd(8'h48, d); check(d, 0, "R7 system ticks ignored");
        rtc_ticks(3);
        rd(8'h48, d); check(d, 3, "R7 slow source");
        wr(8'h44, 32'h11);
        wr(8'h40, 32'h33);
        rtc_ticks(4);
        rd(8'h48, d); check(d, 2, "R7 halved 4 ticks");
        rtc_ticks(1);
        rd(8'h48, d); check(d, 2, "R7 odd tick no count");
        rd(8'h44, d); check(d, 32'h11, "R7 clock word readback");
    endtask

    task automatic t_set_beats_ack;
        logic [31:0] d;
        wr(8'h5C, 32'd2);
        wr(8'h50, 32'h13);
        sys_ticks(1);
        @(negedge clk);
        tick_sys_en = 1'b1; bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h10;
        @(negedge clk);
        tick_sys_en = 1'b0; bus_wr = 1'b0;
        rd(8'h08, d); check(d & 32'h10, 32'h10, "R11 event wins over ack");
        wr(8'h08, 32'h10);
        rd(8'h08, d); check(d & 32'h10, 0, "R8 later ack clears");
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 50000) begin
                n_vec++; n_bad++;
                $display("FAIL watchdog: actual %0d expected <= 50000 cycles", cyc);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_freerun();
        t_repeat_irq();
        t_oneshot();
        t_freeze_clear();
        t_cmp_update();
        t_clock_sel();
        t_set_beats_ack();
        finish_run();
    end

endmodule